// File: doc/BRIEF.md
# Shared EEPROM Serial Pin Port

This block is a software-written serial I/O register that controls the clock and data pins of an external serial EEPROM by direct bit manipulation. The same pins are also controlled by a second, host-side non-volatile memory control register that lives outside this block. The block keeps the serial register's bits, chooses which of the two registers drives the pins, controls the direction of the bidirectional data pin, and brings the level on that pin back into the register.

Control of the pins goes to whichever register was written most recently. After any reset, the host-side register has control. While the reset is applied, the level on the EEPROM clock pin is sampled. A low level there means that no EEPROM is fitted. The port is then marked disabled: its clock output is never driven and the clock bit always reads back as 0.

A separate enable bit arms a sticky interrupt flag. The flag is set while the management data line is low. The four lower bits of the register are held for the management-side interface and are presented on an output bus.

Top module: `eeprom_pin_share`

## Requirements
- R1: A write strobe on `sio_wr` gives pin control to the serial register, and a strobe on `nv_wr` gives it to the host-side register, starting on the next clock edge. When both strobes occur in the same cycle, the host-side register gets control.
- R2: A hardware reset (`rst_n` low) or a software reset (`soft_rst` high at a clock edge) clears every register bit to 0, clears the interrupt flag and gives pin control to the host-side register.
- R3: While the serial register has control and the port is enabled, `ee_clk_o` equals the clock bit (register bit 6). While the host-side register has control and the port is enabled, `ee_clk_o` equals `nv_clk`.
- R4: The level of `ee_clk_in` seen during reset sets the port state. A 0 disables the port: `ee_clk_oe` and `ee_clk_o` stay 0, and read bit 6 is 0 whatever value is written. A 1 enables the port and sets `ee_clk_oe` to 1.
- R5: While the serial register has control and the transmit-enable bit (bit 5) is 1, `ee_data_oe` is 1 and `ee_data_o` equals the data bit (bit 4). The data bit keeps its value until the next write.
- R6: While the transmit-enable bit is 0, the data bit follows `ee_data_in` through a 2-flop synchronizer. A change on the pin appears in read bit 4 on the third rising edge after the change. While the serial register has control, `ee_data_oe` is 0 in this state.
- R7: While the host-side register has control, `ee_data_oe` and `ee_data_o` follow `nv_oe` and `nv_dout`. The serial register keeps its stored bits and still reads them back.
- R8: When the interrupt-enable bit (bit 7) is 1 and `md_in` is low, `mint_flag` is set on the third rising edge after `md_in` falls. The flag stays set until a `mint_clr` pulse. A set condition takes priority over a clear. When bit 7 is 0, a low `md_in` has no effect.
- R9: The register byte is laid out as follows: bit 7 interrupt enable, bit 6 clock, bit 5 transmit enable, bit 4 data, bits 3..0 management bits. The management bits are written as given and appear on `mgmt_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| sio_wr | input | 1 | Write strobe for the serial register byte |
| sio_wdata | input | 8 | Write data for the serial register |
| sio_rdata | output | 8 | Read-back of the serial register |
| nv_wr | input | 1 | Write strobe of the host-side register |
| nv_clk | input | 1 | Clock level requested by the host-side register |
| nv_dout | input | 1 | Data level requested by the host-side register |
| nv_oe | input | 1 | Data drive enable requested by the host-side register |
| ee_clk_in | input | 1 | Sensed level of the EEPROM clock pin |
| ee_clk_o | output | 1 | EEPROM clock pin output value |
| ee_clk_oe | output | 1 | EEPROM clock pin output enable |
| ee_data_in | input | 1 | Sensed level of the EEPROM data pin |
| ee_data_o | output | 1 | EEPROM data pin output value |
| ee_data_oe | output | 1 | EEPROM data pin output enable |
| md_in | input | 1 | Management data line level |
| mint_clr | input | 1 | Clears the interrupt flag |
| mint_flag | output | 1 | Sticky management interrupt flag |
| mgmt_bits | output | 4 | Stored management-side bits |

## Verification
The hardest cases to reach are the disabled port and the tie between the two write strobes. The disabled port only arises when the clock pin is held low during a hardware reset. The bench therefore applies a second hardware reset with that pin low, then writes a clock bit of 1 and confirms that the pin stays quiet and the bit reads 0. For the tie, the bench issues both strobes in one cycle. It chooses the written clock bit and `nv_clk` so that the owner can be read off the clock pin. The synchronizer latency is checked one cycle before and at the cycle the change is due to appear.

// File: rtl/eeprom_pin_share.sv
module eeprom_pin_share #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       sio_wr,
  input  logic [7:0] sio_wdata,
  output logic [7:0] sio_rdata,
  input  logic       nv_wr,
  input  logic       nv_clk,
  input  logic       nv_dout,
  input  logic       nv_oe,
  input  logic       ee_clk_in,
  output logic       ee_clk_o,
  output logic       ee_clk_oe,
  input  logic       ee_data_in,
  output logic       ee_data_o,
  output logic       ee_data_oe,
  input  logic       md_in,
  input  logic       mint_clr,
  output logic       mint_flag,
  output logic [3:0] mgmt_bits
);

  logic minten, eclk, etxen, edata, own_sio, port_en;
  logic [SYNC_STAGES-1:0] dsync, msync;
  logic d_s, m_s;

  assign d_s = dsync[SYNC_STAGES-1];
  assign m_s = msync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {minten, eclk, etxen, edata} <= '0;
      mgmt_bits <= '0;
      own_sio   <= 1'b0;
      mint_flag <= 1'b0;
      dsync     <= '0;
      msync     <= '0;
    end else if (soft_rst) begin
      {minten, eclk, etxen, edata} <= '0;
      mgmt_bits <= '0;
      own_sio   <= 1'b0;
      mint_flag <= 1'b0;
      dsync     <= '0;
      msync     <= '0;
    end else begin
      dsync <= {dsync[SYNC_STAGES-2:0], ee_data_in};
      msync <= {msync[SYNC_STAGES-2:0], md_in};
      if (sio_wr)
        {minten, eclk, etxen, edata, mgmt_bits} <= sio_wdata;
      else if (!etxen)
        edata <= d_s;
      if (nv_wr)
        own_sio <= 1'b0;
      else if (sio_wr)
        own_sio <= 1'b1;
      if (minten && !m_s)
        mint_flag <= 1'b1;
      else if (mint_clr)
        mint_flag <= 1'b0;
    end
  end

  // Port presence is latched from the clock pin level while reset is applied.
  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst)
      port_en <= ee_clk_in;
  end

  assign sio_rdata  = {minten, eclk & port_en, etxen, edata, mgmt_bits};
  assign ee_clk_oe  = port_en;
  assign ee_clk_o   = port_en & (own_sio ? eclk : nv_clk);
  assign ee_data_oe = own_sio ? etxen : nv_oe;
  assign ee_data_o  = own_sio ? edata : nv_dout;

  assert_nv_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |=> !own_sio);
  assert_sio_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_wr && !nv_wr && !soft_rst) |=> own_sio);
  assert_soft_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sio_rdata == 8'h00) && !mint_flag && !own_sio);
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !ee_clk_o && !sio_rdata[6]);
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (etxen && !sio_wr && !soft_rst) |=> $stable(edata));
  assert_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_sio && !etxen) |-> !ee_data_oe);
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (minten && !m_s && !soft_rst) |=> mint_flag);

endmodule

// File: tb/eeprom_pin_share_tb.sv
module eeprom_pin_share_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic sio_wr = 1'b0;
  logic [7:0] sio_wdata = '0, sio_rdata;
  logic nv_wr = 1'b0, nv_clk = 1'b1, nv_dout = 1'b0, nv_oe = 1'b1;
  logic ee_clk_in = 1'b1, ee_clk_o, ee_clk_oe;
  logic ee_data_in = 1'b1, ee_data_o, ee_data_oe;
  logic md_in = 1'b1, mint_clr = 1'b0, mint_flag;
  logic [3:0] mgmt_bits;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_pin_share u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .sio_wr(sio_wr), .sio_wdata(sio_wdata), .sio_rdata(sio_rdata),
    .nv_wr(nv_wr), .nv_clk(nv_clk), .nv_dout(nv_dout), .nv_oe(nv_oe),
    .ee_clk_in(ee_clk_in), .ee_clk_o(ee_clk_o), .ee_clk_oe(ee_clk_oe),
    .ee_data_in(ee_data_in), .ee_data_o(ee_data_o), .ee_data_oe(ee_data_oe),
    .md_in(md_in), .mint_clr(mint_clr), .mint_flag(mint_flag),
    .mgmt_bits(mgmt_bits)
  );

  function automatic logic [16:0] mk(logic coe, logic co, logic doe, logic dout,
                                     logic mi, logic [3:0] mg, logic [7:0] rd);
    return {coe, co, doe, dout, mi, mg, rd};
  endfunction

  wire [16:0] obs = {ee_clk_oe, ee_clk_o, ee_data_oe, ee_data_o, mint_flag, mgmt_bits, sio_rdata};

  always begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (obs !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, obs, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_obs(string tag, logic [16:0] e);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic wr_sio(logic [7:0] v);
    sio_wr = 1'b1; sio_wdata = v;
    tick(1);
    sio_wr = 1'b0;
  endtask

  initial begin
    tick(2);
    expect_obs("R2", mk(1, 1, 1, 0, 0, 4'h0, 8'h00));      // hardware reset state, port sensed present
    rst_n = 1'b1;
    tick(4);
    expect_obs("R6", mk(1, 1, 1, 0, 0, 4'h0, 8'h10));      // data bit follows the high pin
    wr_sio(8'hE5);
    expect_obs("R1", mk(1, 1, 1, 0, 0, 4'h5, 8'hE5));      // R9 layout, serial register takes pins
    wr_sio(8'hF0);
    expect_obs("R5", mk(1, 1, 1, 1, 0, 4'h0, 8'hF0));
    wr_sio(8'hB0);
    expect_obs("R3", mk(1, 0, 1, 1, 0, 4'h0, 8'hB0));
    nv_clk = 1'b0; nv_dout = 1'b1; nv_oe = 1'b0; nv_wr = 1'b1;
    tick(1); nv_wr = 1'b0;
    expect_obs("R7", mk(1, 0, 0, 1, 0, 4'h0, 8'hB0));
    nv_clk = 1'b1; nv_wr = 1'b1;
    wr_sio(8'hA0); nv_wr = 1'b0;
    expect_obs("R1", mk(1, 1, 0, 1, 0, 4'h0, 8'hA0));      // tie goes to host-side register
    wr_sio(8'h60);
    expect_obs("R3", mk(1, 1, 1, 0, 0, 4'h0, 8'h60));
    wr_sio(8'h40);
    expect_obs("R6", mk(1, 1, 0, 0, 0, 4'h0, 8'h40));
    ee_data_in = 1'b0;
    tick(2);
    expect_obs("R6", mk(1, 1, 0, 1, 0, 4'h0, 8'h50));      // not yet through synchronizer
    tick(1);
    expect_obs("R6", mk(1, 1, 0, 0, 0, 4'h0, 8'h40));
    wr_sio(8'hC0);
    md_in = 1'b0;
    tick(2);
    expect_obs("R8", mk(1, 1, 0, 0, 0, 4'h0, 8'hC0));
    tick(1);
    expect_obs("R8", mk(1, 1, 0, 0, 1, 4'h0, 8'hC0));
    md_in = 1'b1;
    tick(4);
    expect_obs("R8", mk(1, 1, 0, 0, 1, 4'h0, 8'hC0));      // sticky
    mint_clr = 1'b1; tick(1); mint_clr = 1'b0;
    expect_obs("R8", mk(1, 1, 0, 0, 0, 4'h0, 8'hC0));
    wr_sio(8'h40);
    md_in = 1'b0;
    tick(4);
    expect_obs("R8", mk(1, 1, 0, 0, 0, 4'h0, 8'h40));      // enable off: low line ignored
    md_in = 1'b1;
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    expect_obs("R2", mk(1, 1, 0, 1, 0, 4'h0, 8'h00));
    rst_n = 1'b0; ee_clk_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    ee_clk_in = 1'b1;
    wr_sio(8'h40);
    expect_obs("R4", mk(0, 0, 0, 0, 0, 4'h0, 8'h00));
    wr_sio(8'hE0);
    expect_obs("R4", mk(0, 0, 1, 0, 0, 4'h0, 8'hA0));
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule